// File: doc/BRIEF.md
# Dual-Core Software-Interrupt Flag Register

This block holds one software-interrupt flag for each core of a two-core system and drives each core's software-interrupt input straight from its flag. Each core has its own write port: a write enable together with a set mask and a clear mask. Each mask has one bit per core flag, and bit k addresses the flag of core k. The flag drives no general system interrupt line. It reaches only its own core's output.

Both cores may write in the same clock cycle. The block ORs the set masks of every enabled port into one set request and does the same with the clear masks. It then applies the combined update once, and a set beats a clear on the same flag. A registered update appears on the outputs one cycle after the write. The current flag vector can also be read back.

The per-core masks travel on one flat bus per kind: core c's mask sits in bits `[c*NCORE +: NCORE]`.

Top module: `swi_ctl_top`

## Requirements
- R1: While reset is asserted (rst_ni low), and on the first cycle after it, every flag, `irq_o` and `flags_rd_o` are 0.
- R2: A write from any core whose set mask has bit k at 1 makes flag k read 1 after the next rising clock edge.
- R3: A write whose clear mask has bit k at 1 makes flag k read 0 after the next edge, provided no enabled port sets bit k in that cycle.
- R4: When a port's write enable is 0, its set and clear masks have no effect on any flag.
- R5: When both cores write in the same cycle, the set masks of both are ORed, the clear masks of both are ORed, and the combined result is applied in that one cycle with nothing lost.
- R6: When flag k is both set and cleared in the same cycle, by one core or by two, flag k ends at 1.
- R7: A flag that no enabled port sets or clears keeps its value, and with no write enabled every flag holds.
- R8: `irq_o[k]` equals flag k at all times, and `flags_rd_o` returns the current flag vector (bit k is core k's flag).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | NCORE | Write enable, bit c for core c's port |
| set_mask_i | input | NCORE*NCORE | Set masks, core c in bits [c*NCORE +: NCORE] |
| clr_mask_i | input | NCORE*NCORE | Clear masks, same layout as set_mask_i |
| irq_o | output | NCORE | Software-interrupt output, bit k to core k |
| flags_rd_o | output | NCORE | Read-back of the current flags |

## Verification
A wrong stored flag shows on both `irq_o` and `flags_rd_o` on the cycle after the faulty update, and it stays visible until a later write corrects it. The risky paths are the merge of two writers and the order of set against clear. A dropped port or a reversed priority shows up as one wrong flag bit one cycle after a simultaneous write. An enable that is ignored shows up as a change in the flags after an idle cycle that should have left them unchanged.

// File: rtl/swi_ctl_pkg.sv
package swi_ctl_pkg;
    localparam int unsigned DEF_CORES = 2;

    // Combined request produced by the merge stage.
    typedef struct packed {
        logic any_write;
    } merge_info_t;
endpackage

// File: rtl/swi_req_merge.sv
module swi_req_merge #(
    parameter int unsigned NCORE = swi_ctl_pkg::DEF_CORES,
    localparam int unsigned MW   = NCORE * NCORE
) (
    input  logic [NCORE-1:0] wr_en_i,
    input  logic [MW-1:0]    set_mask_i,
    input  logic [MW-1:0]    clr_mask_i,
    output logic [NCORE-1:0] set_req_o,
    output logic [NCORE-1:0] clr_req_o,
    output logic             any_write_o
);
    logic [NCORE-1:0] set_gated [NCORE];
    logic [NCORE-1:0] clr_gated [NCORE];

    // Each port contributes its masks only while its enable is high.
    for (genvar c = 0; c < NCORE; c++) begin : g_port
        assign set_gated[c] = wr_en_i[c] ? set_mask_i[c*NCORE +: NCORE] : '0;
        assign clr_gated[c] = wr_en_i[c] ? clr_mask_i[c*NCORE +: NCORE] : '0;
    end

    always_comb begin
        set_req_o = '0;
        clr_req_o = '0;
        for (int c = 0; c < NCORE; c++) begin
            set_req_o = set_req_o | set_gated[c];
            clr_req_o = clr_req_o | clr_gated[c];
        end
        any_write_o = |wr_en_i;
    end
endmodule

// File: rtl/swi_flag_reg.sv
module swi_flag_reg #(
    parameter int unsigned NCORE = swi_ctl_pkg::DEF_CORES
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCORE-1:0] set_req_i,
    input  logic [NCORE-1:0] clr_req_i,
    output logic [NCORE-1:0] flags_o
);
    typedef struct packed {
        logic [NCORE-1:0] flags;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        // Clear first, then set, so a set wins on the same bit.
        state_d.flags = (state_q.flags & ~clr_req_i) | set_req_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flags_o = state_q.flags;
endmodule

// File: rtl/swi_ctl_top.sv
module swi_ctl_top #(
    parameter int unsigned NCORE = swi_ctl_pkg::DEF_CORES,
    localparam int unsigned MW   = NCORE * NCORE
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCORE-1:0] wr_en_i,
    input  logic [MW-1:0]    set_mask_i,
    input  logic [MW-1:0]    clr_mask_i,
    output logic [NCORE-1:0] irq_o,
    output logic [NCORE-1:0] flags_rd_o
);
    logic [NCORE-1:0] set_req;
    logic [NCORE-1:0] clr_req;
    logic             any_write;
    logic [NCORE-1:0] flags;

    swi_req_merge #(.NCORE(NCORE)) i_merge (
        .wr_en_i     (wr_en_i),
        .set_mask_i  (set_mask_i),
        .clr_mask_i  (clr_mask_i),
        .set_req_o   (set_req),
        .clr_req_o   (clr_req),
        .any_write_o (any_write)
    );

    swi_flag_reg #(.NCORE(NCORE)) i_flags (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .set_req_i (set_req),
        .clr_req_i (clr_req),
        .flags_o   (flags)
    );

    assign irq_o      = flags;
    assign flags_rd_o = flags;

    // With no port enabled, the flags must hold (R4, R7).
    p_idle_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !any_write |=> $stable(flags_rd_o));

    for (genvar c = 0; c < NCORE; c++) begin : g_chk_port
        for (genvar k = 0; k < NCORE; k++) begin : g_chk_bit
            p_set_takes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (wr_en_i[c] && set_mask_i[c*NCORE+k]) |=> flags_rd_o[k]);
            p_clear_takes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (wr_en_i[c] && clr_mask_i[c*NCORE+k] && !set_req[k]) |=> !flags_rd_o[k]);
        end
    end

    for (genvar k = 0; k < NCORE; k++) begin : g_chk_flag
        p_set_over_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (set_req[k] && clr_req[k]) |=> irq_o[k]);
    end
endmodule

// File: tb/test_swi_ctl_top.sv
`timescale 1ns/1ps
module test_swi_ctl_top;
    localparam int unsigned NC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   wr_en = '0;
    logic [3:0]   set_m = '0;
    logic [3:0]   clr_m = '0;
    logic [1:0]   irq;
    logic [1:0]   rd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    swi_ctl_top #(.NCORE(NC)) i_swi_ctl_top (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .wr_en_i    (wr_en),
        .set_mask_i (set_m),
        .clr_mask_i (clr_m),
        .irq_o      (irq),
        .flags_rd_o (rd)
    );

    // Vector: {req number, wr_en, set[3:0], clr[3:0], expected flags}
    typedef struct packed {
        logic [3:0] req;
        logic [1:0] en;
        logic [3:0] set;
        logic [3:0] clr;
        logic [1:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 2'b01, 4'b0001, 4'b0000, 2'b01}, // R2 core0 sets flag0
        '{4'd2, 2'b10, 4'b1000, 4'b0000, 2'b11}, // R2 core1 sets flag1
        '{4'd3, 2'b01, 4'b0000, 4'b0001, 2'b10}, // R3 core0 clears flag0
        '{4'd4, 2'b00, 4'b0101, 4'b1010, 2'b10}, // R4 masks without enable
        '{4'd5, 2'b11, 4'b0001, 4'b1000, 2'b01}, // R5 set and clear from two ports
        '{4'd6, 2'b11, 4'b0100, 4'b0001, 2'b01}, // R6 cross-core set vs clear
        '{4'd6, 2'b01, 4'b0001, 4'b0001, 2'b01}, // R6 same-core set vs clear
        '{4'd7, 2'b10, 4'b1000, 4'b0000, 2'b11}, // R7 flag0 untouched keeps 1
        '{4'd5, 2'b11, 4'b0000, 4'b0110, 2'b00}, // R5 clears ORed from two ports
        '{4'd4, 2'b10, 4'b1100, 4'b0011, 2'b11}, // R4 disabled clear ignored
        '{4'd3, 2'b11, 4'b0000, 4'b1111, 2'b00}  // R3 clear both flags
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic write(input logic [1:0] en, input logic [3:0] s, input logic [3:0] c);
        @(negedge clk);
        wr_en = en; set_m = s; clr_m = c;
        @(negedge clk);
        wr_en = '0; set_m = '0; clr_m = '0;
    endtask

    initial begin
        #12;
        check("R1 reset rd", rd, 2'b00);
        check("R1 reset irq", irq, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", rd, 2'b00);

        for (int i = 0; i < NV; i++) begin
            write(VECS[i].en, VECS[i].set, VECS[i].clr);
            check($sformatf("R%0d vector %0d rd", VECS[i].req, i), rd, VECS[i].exp);
            check($sformatf("R8 vector %0d irq", i), irq, VECS[i].exp);
        end

        // R7: idle cycles keep the flags
        write(2'b11, 4'b1001, 4'b0000);
        check("R2 both set", rd, 2'b11);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            check("R7 idle hold", rd, 2'b11);
        end

        // R4: enable low with set masks must not raise a cleared flag
        write(2'b01, 4'b0000, 4'b0011);
        check("R3 core0 clears both", rd, 2'b00);
        write(2'b00, 4'b1111, 4'b0000);
        check("R4 disabled set ignored", irq, 2'b00);

        // R1: reset in the middle of operation clears the flags
        write(2'b01, 4'b0011, 4'b0000);
        check("R2 core0 sets both", rd, 2'b11);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 async reset", irq, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after second reset", rd, 2'b00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule